// File: doc/BRIEF.md
# Decode-Stage Next-PC Resolver

This block chooses the program counter for a five-stage 32-bit pipeline whose branches and jumps are settled in the decode stage. The fetch side supplies the incremented address (PC+4). The decode stage supplies the current instruction word and two comparison operands, which the forwarding network has already chosen. From these the block forms a region jump target and a PC-relative branch target. It tests the two operands for equality and selects the next address. The program counter register sits inside the block.

The pipeline has one delayed branch slot. The instruction that follows a branch or jump always executes, so the block issues no flush or squash. It only redirects the next fetch address. A taken flag reports each redirect to the rest of the pipeline.

Top module: `id_branch_resolver`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_o` is loaded with address 0 (synchronous reset), even when the instruction in decode is a jump.
- R2: At every rising edge with `rst` low, `pc_o` takes the value `next_pc_o` had just before that edge.
- R3: When the opcode in instruction bits 31..26 is 000010 (jump), `next_pc_o` is PC+4 bits 31..28, then instruction bits 25..0, then two zero bits, and `taken_o` is 1. The operands have no effect.
- R4: When the opcode is 000100 (branch-if-equal) and the two 32-bit operands are equal, `next_pc_o` is PC+4 plus four times the signed 16-bit immediate in instruction bits 15..0, and `taken_o` is 1.
- R5: When the opcode is 000100 and the operands differ in any single bit, `next_pc_o` equals PC+4 and `taken_o` is 0.
- R6: Immediates with bit 15 set give backward targets (PC+4 minus the magnitude times four), with wraparound modulo 2^32.
- R7: For every other opcode, `next_pc_o` equals PC+4 and `taken_o` is 0, whatever the operands and the other instruction bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_plus4_i | input | 32 | Incremented fetch address |
| id_insn_i | input | 32 | Instruction word in decode |
| cmp_a_i | input | 32 | First comparison operand, already forwarded |
| cmp_b_i | input | 32 | Second comparison operand, already forwarded |
| next_pc_o | output | 32 | Address selected for the next fetch |
| taken_o | output | 1 | High when fetch is redirected |
| pc_o | output | 32 | Program counter register |

## Verification
The branch immediate is swept in even steps across its whole range, and both sign extremes are included. This separates forward targets from backward ones and catches sign-extension and shift errors. Jumps run with every upper nibble of PC+4 and with several target fields, to show that the region bits come from PC+4 and the low bits from the instruction. Branches with operands that differ in exactly one bit position test every lane of the comparator. All 64 opcodes with equal operands show that only the two control opcodes redirect, and a jump held during reset shows that reset takes priority.

// File: rtl/pcres_pkg.sv
package pcres_pkg;
  localparam int OP_HI = 31;
  localparam int OP_LO = 26;
  localparam int OP_W  = OP_HI - OP_LO + 1;

  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP   = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/branch_target_gen.sv
module branch_target_gen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0] pc_plus4,
  input  logic [XLEN-1:0] insn,
  output logic [XLEN-1:0] target
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  imm_sx;
  logic [XLEN-1:0]  byte_off;

  always_comb begin
    imm      = insn[IMM_W-1:0];
    imm_sx   = {{EXT_W{imm[IMM_W-1]}}, imm};
    byte_off = {imm_sx[XLEN-3:0], 2'b00};
    target   = pc_plus4 + byte_off;
  end
endmodule

// File: rtl/jump_target_gen.sv
module jump_target_gen #(
  parameter int XLEN    = 32,
  parameter int FIELD_W = 26
) (
  input  logic [XLEN-1:0] pc_plus4,
  input  logic [XLEN-1:0] insn,
  output logic [XLEN-1:0] target
);
  localparam int REGION_LO = FIELD_W + 2;

  always_comb target = {pc_plus4[XLEN-1:REGION_LO], insn[FIELD_W-1:0], 2'b00};
endmodule

// File: rtl/eq_compare.sv
module eq_compare #(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            equal
);
  localparam int LANES = XLEN / LANE_W;

  logic [LANES-1:0] lane_eq;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (a[g*LANE_W +: LANE_W] == b[g*LANE_W +: LANE_W]);
  end

  assign equal = &lane_eq;
endmodule

// File: rtl/id_branch_resolver.sv
module id_branch_resolver
  import pcres_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0] OP_JMP   = 6'b000010,
  parameter logic [31:0]     RESET_PC = 32'h0000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pc_plus4_i,
  input  logic [XLEN-1:0] id_insn_i,
  input  logic [XLEN-1:0] cmp_a_i,
  input  logic [XLEN-1:0] cmp_b_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic [XLEN-1:0] pc_o
);
  logic [OP_W-1:0] opcode;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;
  logic            ops_equal;
  npc_sel_e        sel;
  logic [XLEN-1:0] pc_q;

  assign opcode = id_insn_i[OP_HI:OP_LO];

  branch_target_gen #(.XLEN(XLEN), .IMM_W(16)) u_br (
    .pc_plus4(pc_plus4_i), .insn(id_insn_i), .target(br_target));

  jump_target_gen #(.XLEN(XLEN), .FIELD_W(26)) u_jmp (
    .pc_plus4(pc_plus4_i), .insn(id_insn_i), .target(jmp_target));

  eq_compare #(.XLEN(XLEN), .LANE_W(8)) u_eq (
    .a(cmp_a_i), .b(cmp_b_i), .equal(ops_equal));

  always_comb begin
    sel = NPC_SEQ;
    if (opcode == OP_JMP)                   sel = NPC_JUMP;
    else if (opcode == OP_BEQ && ops_equal) sel = NPC_BRANCH;
  end

  always_comb begin
    unique case (sel)
      NPC_JUMP:   next_pc_o = jmp_target;
      NPC_BRANCH: next_pc_o = br_target;
      default:    next_pc_o = pc_plus4_i;
    endcase
    taken_o = (sel != NPC_SEQ);
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC[XLEN-1:0];
    else     pc_q <= next_pc_o;
  end

  assign pc_o = pc_q;

  p_reset_pc_r1: assert property (@(posedge clk)
    rst |=> pc_q == RESET_PC[XLEN-1:0]);

  p_pc_load_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pc_q == $past(next_pc_o));

  p_jump_region_r3: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_JMP) |-> (taken_o && next_pc_o[1:0] == 2'b00
                            && next_pc_o[XLEN-1:XLEN-4] == pc_plus4_i[XLEN-1:XLEN-4]));

  p_beq_equal_r4: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_BEQ && cmp_a_i == cmp_b_i) |-> taken_o);

  p_beq_differ_r5: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_BEQ && cmp_a_i != cmp_b_i) |-> (!taken_o && next_pc_o == pc_plus4_i));

  p_other_seq_r7: assert property (@(posedge clk) disable iff (rst)
    (opcode != OP_BEQ && opcode != OP_JMP) |-> (!taken_o && next_pc_o == pc_plus4_i));
endmodule

// File: tb/tb_id_branch_resolver.sv
module tb_id_branch_resolver;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pc4, insn, opa, opb;
  logic [31:0] next_pc, pc;
  logic        taken;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 0;

  always #4 clk = ~clk;

  id_branch_resolver dut (
    .clk(clk), .rst(rst), .pc_plus4_i(pc4), .id_insn_i(insn),
    .cmp_a_i(opa), .cmp_b_i(opb),
    .next_pc_o(next_pc), .taken_o(taken), .pc_o(pc));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [31:0] p4, input logic [31:0] iw,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] exp_npc, input logic exp_tk);
    @(negedge clk);
    pc4 = p4; insn = iw; opa = a; opb = b;
    #1;
    chk(req, next_pc, exp_npc);
    chk(req, {31'b0, taken}, {31'b0, exp_tk});
    @(posedge clk); #1;
    chk("R2", pc, exp_npc);
  endtask

  function automatic logic [31:0] br_exp(input logic [31:0] p4, input logic [15:0] imm);
    int off;
    off = int'($signed(imm)) * 4;
    return p4 + 32'(off);
  endfunction

  initial begin
    rst = 1'b1; pc4 = 32'h0000_1004; insn = {6'b000010, 26'h3ff_ffff}; opa = 0; opb = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", pc, 32'h0);
    @(negedge clk); rst = 1'b0;
    // R4/R6: immediate sweep, equal operands
    for (int i = 0; i < 65536; i += 251) begin
      logic [31:0] p4;
      p4 = 32'h4000_0000 + 32'(i * 12);
      apply("R4", p4, {6'b000100, 5'd3, 5'd4, 16'(i)}, 32'h1234_5678, 32'h1234_5678,
            br_exp(p4, 16'(i)), 1'b1);
    end
    apply("R6", 32'h0000_042c, {6'b000100, 10'd0, 16'hffe7}, 7, 7, 32'h0000_03c8, 1'b1);
    apply("R6", 32'h0000_0010, {6'b000100, 10'd0, 16'h8000}, 0, 0, 32'hfffe_0010, 1'b1);
    apply("R4", 32'hffff_fff0, {6'b000100, 10'd0, 16'h7fff}, 0, 0, 32'h0001_ffec, 1'b1);
    apply("R6", 32'h0000_0100, {6'b000100, 10'd0, 16'hffff}, 5, 5, 32'h0000_00fc, 1'b1);
    // R5: single-bit differences
    for (int k = 0; k < 32; k++)
      apply("R5", 32'h0000_2000 + 32'(k * 4), {6'b000100, 10'd0, 16'h0010},
            32'hA5A5_0F0F, 32'hA5A5_0F0F ^ (32'h1 << k), 32'h0000_2000 + 32'(k * 4), 1'b0);
    // R3: jump keeps region of PC+4
    for (int n = 0; n < 16; n++) begin
      logic [31:0] p4; logic [25:0] f;
      p4 = {4'(n), 28'h0ab_cde4};
      f  = 26'(n * 26'h0123457) ^ 26'h2aa_aaaa;
      apply("R3", p4, {6'b000010, f}, 32'h1, 32'h2, (p4 & 32'hf000_0000) | (32'(f) << 2), 1'b1);
    end
    apply("R3", 32'hf000_0000, {6'b000010, 26'h000_0000}, 0, 0, 32'hf000_0000, 1'b1);
    // R7: every opcode, equal operands
    for (int o = 0; o < 64; o++) begin
      logic [31:0] p4, e; logic t;
      p4 = 32'h0010_0000 + 32'(o * 8);
      if (o == 2)      begin e = (p4 & 32'hf000_0000) | (32'h0000_1234 << 2); t = 1'b1; end
      else if (o == 4) begin e = p4 + 32'h0000_48d0; t = 1'b1; end
      else             begin e = p4; t = 1'b0; end
      apply((o == 2 || o == 4) ? "R3" : "R7", p4, {6'(o), 10'd0, 16'h1234}, 9, 9, e, t);
    end
    // R1: reset wins over a taken jump
    @(negedge clk);
    rst = 1'b1; insn = {6'b000010, 26'h155_5555}; pc4 = 32'h8000_0004;
    @(posedge clk); #1;
    chk("R1", pc, 32'h0);
    rst = 1'b0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule